// File: doc/BRIEF.md
# Direct-Mapped Memory-Side Cache Controller

This block holds the tag and lookup logic for a cache that sits on the memory side of a system. A small, fast memory stores the data, and a large bulk memory stands behind it. Every line in the fast memory carries its own valid bit, dirty bit and tag beside the 64-byte data, so a single fast-memory read gives the controller everything it needs to decide hit or miss. Lines are direct mapped. A read miss writes any dirty victim back to bulk memory, then fills the line from bulk memory. A write miss fills the line and then merges the write data into it.

A mode strap is sampled while reset is asserted, and it decides how the fast memory is split. In full-cache mode every fast line caches bulk memory. In flat mode no line caches, and the whole fast memory is ordinary addressable storage. In the two hybrid modes a quarter or a half of the fast memory caches, and the remaining lines are addressable storage. Bulk and fast storage share one physical line address space. Requests are handled strictly one at a time. The request, fast-memory and bulk-memory ports each use a valid/ready handshake.

Top module: `memside_cache`

## Requirements
- R1: After reset is released, the controller writes a fast-memory word with the valid bit cleared into every cache line. `req_ready` stays low until that sweep has finished, so the first read of any bulk address is a miss. The fast-memory word layout is data in bits [DW-1:0], tag (a full bulk line address) above it, then dirty, with valid as the top bit.
- R2: `mode_i` is sampled only while `rst` is high. The encoding is 0 = full cache, 1 = flat, 2 = hybrid with a quarter cached, 3 = hybrid with a half cached. Changes to `mode_i` after reset have no effect.
- R3: `req_addr` with bit BULK_AW clear selects bulk line address `req_addr[BULK_AW-1:0]`. It is cached in set `addr mod C`, where C is the number of cache lines for the mode (all, 0, 1/4 or 1/2 of the fast lines). Two addresses that are equal mod C evict each other.
- R4: A read hit returns the stored line with no bulk-memory request. Any bulk read, whether cached or not, returns the latest data written to that address.
- R5: On a miss whose victim is valid and dirty, the victim is written to bulk memory at its tagged address before the requested line is read. The read response carries the bulk data.
- R6: A write hit replaces the line, marks it dirty and makes no bulk request. A write miss reads the line from bulk memory, replaces it with the write data and marks it dirty.
- R7: With `req_addr[BULK_AW]` set, offset `req_addr[BULK_AW-1:0]` below the flat size (fast lines minus C) maps to fast line C + offset. It is read or written directly, with no tag check and no bulk request.
- R8: A flat-region access whose offset is not below the flat size is dropped. A write changes nothing, and a read returns zero.
- R9: In flat mode, bulk-region requests go straight to bulk memory and make no fast-memory request.
- R10: `req_ready` is high only while no request is in progress, and no memory request is issued in that state. Each accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R11: A fast-memory or bulk-memory request that is stalled by its ready signal holds valid, write enable and index/address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Partition strap, sampled during reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | BULK_AW+1 | Line address; top bit selects the flat region |
| req_wdata | input | 512 | Write line |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 512 | Read line, valid with rsp_valid |
| fm_req_valid | output | 1 | Fast-memory request valid |
| fm_req_ready | input | 1 | Fast-memory request accepted |
| fm_we | output | 1 | Fast-memory write |
| fm_idx | output | FAST_AW | Fast-memory line index |
| fm_wline | output | 512+BULK_AW+2 | Fast-memory write word (valid, dirty, tag, data) |
| fm_rvalid | input | 1 | Fast-memory read return valid |
| fm_rline | input | 512+BULK_AW+2 | Fast-memory read word |
| bm_req_valid | output | 1 | Bulk-memory request valid |
| bm_req_ready | input | 1 | Bulk-memory request accepted |
| bm_we | output | 1 | Bulk-memory write |
| bm_addr | output | BULK_AW | Bulk line address |
| bm_wdata | output | 512 | Bulk write line |
| bm_rvalid | input | 1 | Bulk read return valid |
| bm_rdata | input | 512 | Bulk read line |

## Verification
The assertions check the handshake discipline on every cycle. They cover the single-cycle completion pulse, the quiet memory ports while a request is being accepted, and the stability of stalled fast and bulk requests. Only the bench scenarios can show the cache effects themselves. These are whether a request hits or misses, the ordering of write-back before fill, aliasing between addresses in each partition mode, the dropping of out-of-range flat accesses, and the fact that the mode strap stops mattering once reset is released. The bench checks them by counting memory transactions and by comparing read data against a reference model of the address space.

// File: rtl/msc_pkg.sv
package msc_pkg;

    localparam int LINE_BYTES = 64;
    localparam int DW         = LINE_BYTES * 8;

    typedef enum logic [1:0] {
        MODE_CACHE    = 2'd0,
        MODE_FLAT     = 2'd1,
        MODE_HYB_QTR  = 2'd2,
        MODE_HYB_HALF = 2'd3
    } msc_mode_e;

    typedef enum logic [3:0] {
        ST_INIT, ST_IDLE, ST_DISP, ST_LK_REQ, ST_LK_WAIT, ST_WB,
        ST_FILL_REQ, ST_FILL_WAIT, ST_FAST_WR, ST_FLAT_REQ, ST_FLAT_WAIT,
        ST_BYP_REQ, ST_BYP_WAIT, ST_RESP
    } msc_state_e;

    // number of fast lines used as cache for a partition mode
    function automatic int cache_lines_f(msc_mode_e m, int fast_aw);
        case (m)
            MODE_CACHE:    return 1 << fast_aw;
            MODE_HYB_QTR:  return 1 << (fast_aw - 2);
            MODE_HYB_HALF: return 1 << (fast_aw - 1);
            default:       return 0;
        endcase
    endfunction

endpackage

// File: rtl/msc_addr_map.sv
module msc_addr_map #(
    parameter int BULK_AW = 8,
    parameter int FAST_AW = 4
) (
    input  msc_pkg::msc_mode_e  mode,
    input  logic [BULK_AW:0]    addr,
    output logic                is_flat,
    output logic                flat_ok,
    output logic                cache_en,
    output logic [FAST_AW-1:0]  set_idx,
    output logic [FAST_AW-1:0]  flat_idx
);
    localparam int CW = FAST_AW + 1;
    localparam int FL = 1 << FAST_AW;

    logic [CW-1:0]      c_lines;
    logic [CW-1:0]      flat_sz;
    logic [FAST_AW-1:0] mask;
    logic [BULK_AW-1:0] off;

    always_comb begin
        c_lines  = CW'(msc_pkg::cache_lines_f(mode, FAST_AW));
        flat_sz  = CW'(FL) - c_lines;
        mask     = c_lines[FAST_AW-1:0] - FAST_AW'(1);
        off      = addr[BULK_AW-1:0];
        is_flat  = addr[BULK_AW];
        cache_en = (c_lines != '0);
        flat_ok  = is_flat && (off < BULK_AW'(flat_sz));
        set_idx  = addr[FAST_AW-1:0] & mask;
        flat_idx = c_lines[FAST_AW-1:0] + off[FAST_AW-1:0];
    end
endmodule

// File: rtl/msc_tag_check.sv
module msc_tag_check #(
    parameter int BULK_AW = 8
) (
    input  logic               ln_valid,
    input  logic               ln_dirty,
    input  logic [BULK_AW-1:0] ln_tag,
    input  logic [BULK_AW-1:0] want_tag,
    output logic               hit,
    output logic               evict_dirty
);
    always_comb begin
        hit         = ln_valid && (ln_tag == want_tag);
        evict_dirty = ln_valid && ln_dirty && !hit;
    end
endmodule

// File: rtl/memside_cache.sv
module memside_cache #(
    parameter int BULK_AW = 8,
    parameter int FAST_AW = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [1:0]                          mode_i,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic                                req_we,
    input  logic [BULK_AW:0]                    req_addr,
    input  logic [msc_pkg::DW-1:0]              req_wdata,
    output logic                                rsp_valid,
    output logic [msc_pkg::DW-1:0]              rsp_rdata,
    output logic                                fm_req_valid,
    input  logic                                fm_req_ready,
    output logic                                fm_we,
    output logic [FAST_AW-1:0]                  fm_idx,
    output logic [msc_pkg::DW+BULK_AW+1:0]      fm_wline,
    input  logic                                fm_rvalid,
    input  logic [msc_pkg::DW+BULK_AW+1:0]      fm_rline,
    output logic                                bm_req_valid,
    input  logic                                bm_req_ready,
    output logic                                bm_we,
    output logic [BULK_AW-1:0]                  bm_addr,
    output logic [msc_pkg::DW-1:0]              bm_wdata,
    input  logic                                bm_rvalid,
    input  logic [msc_pkg::DW-1:0]              bm_rdata
);
    import msc_pkg::*;

    typedef struct packed {
        logic               valid;
        logic               dirty;
        logic [BULK_AW-1:0] tag;
        logic [DW-1:0]      data;
    } line_t;

    msc_state_e         state;
    msc_mode_e          mode_q;
    logic [FAST_AW-1:0] init_cnt;
    logic               r_we;
    logic [BULK_AW:0]   r_addr;
    logic [DW-1:0]      r_wdata;
    logic [DW-1:0]      r_rdata;
    line_t              r_line;
    line_t              rd_line;

    logic               is_flat, flat_ok, cache_en;
    logic [FAST_AW-1:0] set_idx, flat_idx;
    logic               hit, evict_dirty;

    assign rd_line = line_t'(fm_rline);

    msc_addr_map #(.BULK_AW(BULK_AW), .FAST_AW(FAST_AW)) u_map (
        .mode(mode_q), .addr(r_addr), .is_flat(is_flat), .flat_ok(flat_ok),
        .cache_en(cache_en), .set_idx(set_idx), .flat_idx(flat_idx)
    );

    msc_tag_check #(.BULK_AW(BULK_AW)) u_tag (
        .ln_valid(rd_line.valid), .ln_dirty(rd_line.dirty), .ln_tag(rd_line.tag),
        .want_tag(r_addr[BULK_AW-1:0]), .hit(hit), .evict_dirty(evict_dirty)
    );

    // sweep ends on the last cache line
    logic [FAST_AW:0] last_init;
    assign last_init = (FAST_AW+1)'(cache_lines_f(mode_q, FAST_AW)) - 1'b1;

    always_comb begin
        req_ready    = (state == ST_IDLE);
        rsp_valid    = (state == ST_RESP);
        rsp_rdata    = r_rdata;
        fm_req_valid = (state == ST_INIT && cache_en) || state == ST_LK_REQ ||
                       state == ST_FAST_WR || state == ST_FLAT_REQ;
        fm_we        = !(state == ST_LK_REQ || (state == ST_FLAT_REQ && !r_we));
        fm_idx       = set_idx;
        fm_wline     = r_line;
        unique case (state)
            ST_INIT:     begin fm_idx = init_cnt; fm_wline = '0; end
            ST_FLAT_REQ: begin fm_idx = flat_idx; fm_wline = line_t'{1'b0, 1'b0, '0, r_wdata}; end
            default: ;
        endcase
        bm_req_valid = (state == ST_WB) || (state == ST_FILL_REQ) || (state == ST_BYP_REQ);
        bm_we        = (state == ST_WB) || (state == ST_BYP_REQ && r_we);
        bm_addr      = (state == ST_WB) ? r_line.tag  : r_addr[BULK_AW-1:0];
        bm_wdata     = (state == ST_WB) ? r_line.data : r_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_INIT;
            mode_q   <= msc_mode_e'(mode_i);
            init_cnt <= '0;
            r_we     <= 1'b0;
            r_addr   <= '0;
            r_wdata  <= '0;
            r_rdata  <= '0;
            r_line   <= '0;
        end else begin
            unique case (state)
                ST_INIT: begin
                    if (!cache_en) state <= ST_IDLE;
                    else if (fm_req_ready) begin
                        init_cnt <= init_cnt + 1'b1;
                        if ({1'b0, init_cnt} == last_init) state <= ST_IDLE;
                    end
                end
                ST_IDLE: if (req_valid) begin
                    r_we    <= req_we;
                    r_addr  <= req_addr;
                    r_wdata <= req_wdata;
                    r_rdata <= '0;
                    state   <= ST_DISP;
                end
                ST_DISP: begin
                    if (is_flat)       state <= flat_ok ? ST_FLAT_REQ : ST_RESP;
                    else if (cache_en) state <= ST_LK_REQ;
                    else               state <= ST_BYP_REQ;
                end
                ST_LK_REQ: if (fm_req_ready) state <= ST_LK_WAIT;
                ST_LK_WAIT: if (fm_rvalid) begin
                    r_line <= rd_line;
                    if (hit) begin
                        if (r_we) begin
                            r_line <= line_t'{1'b1, 1'b1, r_addr[BULK_AW-1:0], r_wdata};
                            state  <= ST_FAST_WR;
                        end else begin
                            r_rdata <= rd_line.data;
                            state   <= ST_RESP;
                        end
                    end else begin
                        state <= evict_dirty ? ST_WB : ST_FILL_REQ;
                    end
                end
                ST_WB:       if (bm_req_ready) state <= ST_FILL_REQ;
                ST_FILL_REQ: if (bm_req_ready) state <= ST_FILL_WAIT;
                ST_FILL_WAIT: if (bm_rvalid) begin
                    r_rdata <= bm_rdata;
                    r_line  <= line_t'{1'b1, r_we, r_addr[BULK_AW-1:0], r_we ? r_wdata : bm_rdata};
                    state   <= ST_FAST_WR;
                end
                ST_FAST_WR:  if (fm_req_ready) state <= ST_RESP;
                ST_FLAT_REQ: if (fm_req_ready) state <= r_we ? ST_RESP : ST_FLAT_WAIT;
                ST_FLAT_WAIT: if (fm_rvalid) begin
                    r_rdata <= rd_line.data;
                    state   <= ST_RESP;
                end
                ST_BYP_REQ:  if (bm_req_ready) state <= r_we ? ST_RESP : ST_BYP_WAIT;
                ST_BYP_WAIT: if (bm_rvalid) begin
                    r_rdata <= bm_rdata;
                    state   <= ST_RESP;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msc_checker.sv
module msc_checker #(
    parameter int BULK_AW = 8,
    parameter int FAST_AW = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               fm_req_valid,
    input logic               fm_req_ready,
    input logic               fm_we,
    input logic [FAST_AW-1:0] fm_idx,
    input logic               bm_req_valid,
    input logic               bm_req_ready,
    input logic               bm_we,
    input logic [BULK_AW-1:0] bm_addr
);
    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!fm_req_valid && !bm_req_valid && !rsp_valid));

    assert_fm_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (fm_req_valid && !fm_req_ready) |=> (fm_req_valid && $stable(fm_we) && $stable(fm_idx)));

    assert_bm_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (bm_req_valid && !bm_req_ready) |=> (bm_req_valid && $stable(bm_we) && $stable(bm_addr)));
endmodule

bind memside_cache msc_checker #(.BULK_AW(BULK_AW), .FAST_AW(FAST_AW)) u_msc_checker (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .fm_req_valid(fm_req_valid), .fm_req_ready(fm_req_ready), .fm_we(fm_we),
    .fm_idx(fm_idx), .bm_req_valid(bm_req_valid), .bm_req_ready(bm_req_ready),
    .bm_we(bm_we), .bm_addr(bm_addr)
);

// File: tb/test_memside_cache.sv
module test_memside_cache;
    localparam int BAW = 8;
    localparam int FAW = 4;
    localparam int DW  = 512;
    localparam int LW  = DW + BAW + 2;
    localparam int NF  = 1 << FAW;
    localparam int NB  = 1 << BAW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_i = 2'd0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [BAW:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic fm_req_valid, fm_we, fm_rvalid;
    logic fm_req_ready;
    logic [FAW-1:0] fm_idx;
    logic [LW-1:0] fm_wline, fm_rline;
    logic bm_req_valid, bm_we, bm_rvalid;
    logic bm_req_ready;
    logic [BAW-1:0] bm_addr;
    logic [DW-1:0] bm_wdata, bm_rdata;

    always #4 clk = ~clk;

    memside_cache #(.BULK_AW(BAW), .FAST_AW(FAW)) i_memside_cache (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .fm_req_valid(fm_req_valid), .fm_req_ready(fm_req_ready), .fm_we(fm_we),
        .fm_idx(fm_idx), .fm_wline(fm_wline), .fm_rvalid(fm_rvalid), .fm_rline(fm_rline),
        .bm_req_valid(bm_req_valid), .bm_req_ready(bm_req_ready), .bm_we(bm_we),
        .bm_addr(bm_addr), .bm_wdata(bm_wdata), .bm_rvalid(bm_rvalid), .bm_rdata(bm_rdata)
    );

    function automatic logic [DW-1:0] bval(int a);
        return {16{24'hB1C2D3, 8'(a)}};
    endfunction

    function automatic int cache_n(int m);
        case (m)
            0: return NF;
            2: return NF / 4;
            3: return NF / 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [DW-1:0] rand_line();
        logic [DW-1:0] d;
        for (int i = 0; i < DW / 32; i++) d[i*32 +: 32] = $urandom;
        return d;
    endfunction

    // behavioural memories
    logic [LW-1:0] fmem [NF];
    logic [DW-1:0] bmem [NB];
    int fm_ops = 0, bm_ops = 0;
    logic bm_log_we [64];
    logic [BAW-1:0] bm_log_addr [64];

    always @(negedge clk) begin
        fm_req_ready <= ($urandom_range(3) != 0);
        bm_req_ready <= ($urandom_range(3) != 0);
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NF; i++) fmem[i] <= '1;
            for (int i = 0; i < NB; i++) bmem[i] <= bval(i);
            fm_rvalid <= 1'b0;
            bm_rvalid <= 1'b0;
        end else begin
            fm_rvalid <= 1'b0;
            bm_rvalid <= 1'b0;
            if (fm_req_valid && fm_req_ready) begin
                if (fm_we) fmem[fm_idx] <= fm_wline;
                else begin fm_rvalid <= 1'b1; fm_rline <= fmem[fm_idx]; end
                fm_ops <= fm_ops + 1;
            end
            if (bm_req_valid && bm_req_ready) begin
                if (bm_we) bmem[bm_addr] <= bm_wdata;
                else begin bm_rvalid <= 1'b1; bm_rdata <= bmem[bm_addr]; end
                bm_log_we[bm_ops % 64]   <= bm_we;
                bm_log_addr[bm_ops % 64] <= bm_addr;
                bm_ops <= bm_ops + 1;
            end
        end
    end

    // reference model
    logic [DW-1:0] ref_bulk [NB];
    logic [DW-1:0] ref_flat [NF];
    int cur_mode = 0;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk_i(string r, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic chk_d(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", r, act[63:0], exp[63:0]);
        end
    endtask

    task automatic do_reset(int m);
        @(negedge clk);
        rst = 1'b1; mode_i = 2'(m); cur_mode = m;
        for (int i = 0; i < NB; i++) ref_bulk[i] = bval(i);
        for (int i = 0; i < NF; i++) ref_flat[i] = '1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        if (m != 1) chk_i("R1 ready low during sweep", longint'(req_ready), 0);
        chk_i("R10 no response after reset", longint'(rsp_valid), 0);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic xact(input logic we, input logic [BAW:0] addr, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int dfm, output int dbm);
        int f0 = fm_ops;
        int b0 = bm_ops;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata;
        @(negedge clk);
        chk_i("R10 single-cycle response", longint'(rsp_valid), 0);
        dfm = fm_ops - f0;
        dbm = bm_ops - b0;
    endtask

    function automatic logic [BAW:0] fa(int off);
        return {1'b1, BAW'(off)};
    endfunction

    task automatic random_phase(int n);
        logic [DW-1:0] rd, d;
        int dfm, dbm, off, a;
        int fsz = NF - cache_n(cur_mode);
        for (int k = 0; k < n; k++) begin
            d = rand_line();
            if ($urandom_range(3) == 0) begin
                off = $urandom_range(NF + 1);
                if ($urandom_range(1) == 1) begin
                    xact(1'b1, fa(off), d, rd, dfm, dbm);
                    if (off < fsz) ref_flat[off] = d;
                end else begin
                    xact(1'b0, fa(off), '0, rd, dfm, dbm);
                    chk_d("R7 flat read", rd, (off < fsz) ? ref_flat[off] : '0);
                end
            end else begin
                a = $urandom_range(47);
                if ($urandom_range(1) == 1) begin
                    xact(1'b1, {1'b0, BAW'(a)}, d, rd, dfm, dbm);
                    ref_bulk[a] = d;
                end else begin
                    xact(1'b0, {1'b0, BAW'(a)}, '0, rd, dfm, dbm);
                    chk_d("R4 bulk read", rd, ref_bulk[a]);
                end
            end
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd, d1, d2, d3;
        int dfm, dbm, b0, allv;
        void'($urandom(32'd2024));

        // full cache mode
        do_reset(0);
        allv = 0;
        for (int i = 0; i < NF; i++) allv += int'(fmem[i][LW-1]);
        chk_i("R1 valid bits cleared", allv, 0);
        xact(1'b0, 9'd5, '0, rd, dfm, dbm);
        chk_i("R1 first read misses", dbm, 1);
        chk_d("R3 miss data", rd, bval(5));
        xact(1'b0, 9'd5, '0, rd, dfm, dbm);
        chk_i("R4 hit no bulk access", dbm, 0);
        chk_d("R4 hit data", rd, bval(5));
        d1 = rand_line();
        xact(1'b1, 9'd5, d1, rd, dfm, dbm);
        chk_i("R6 write hit no bulk access", dbm, 0);
        chk_i("R6 write hit dirty", longint'(fmem[5][LW-2]), 1);
        xact(1'b0, 9'd5, '0, rd, dfm, dbm);
        chk_d("R6 write hit data", rd, d1);
        d2 = rand_line();
        b0 = bm_ops;
        xact(1'b1, 9'd7, d2, rd, dfm, dbm);
        chk_i("R6 write miss fills once", dbm, 1);
        chk_i("R6 write miss fill is read", longint'(bm_log_we[b0 % 64]), 0);
        xact(1'b0, 9'd7, '0, rd, dfm, dbm);
        chk_d("R6 write miss merged", rd, d2);
        b0 = bm_ops;
        xact(1'b0, 9'd21, '0, rd, dfm, dbm);
        chk_i("R5 two bulk ops", dbm, 2);
        chk_i("R5 first op is write", longint'(bm_log_we[b0 % 64]), 1);
        chk_i("R5 victim address", longint'(bm_log_addr[b0 % 64]), 5);
        chk_i("R5 then read", longint'(bm_log_we[(b0 + 1) % 64]), 0);
        chk_i("R5 read address", longint'(bm_log_addr[(b0 + 1) % 64]), 21);
        chk_d("R5 victim data in bulk", bmem[5], d1);
        chk_d("R5 returned data", rd, bval(21));
        ref_bulk[5] = d1; ref_bulk[7] = d2;
        xact(1'b1, fa(0), rand_line(), rd, dfm, dbm);
        xact(1'b0, fa(0), '0, rd, dfm, dbm);
        chk_d("R8 no flat space in cache mode", rd, '0);
        random_phase(150);

        // hybrid quarter; strap moved after reset
        do_reset(2);
        mode_i = 2'd1;
        xact(1'b0, 9'd1, '0, rd, dfm, dbm);
        xact(1'b0, 9'd5, '0, rd, dfm, dbm);
        xact(1'b0, 9'd1, '0, rd, dfm, dbm);
        chk_i("R3 quarter aliasing misses", dbm, 1);
        chk_i("R2 cache still active", dfm > 0 ? 1 : 0, 1);
        d3 = rand_line();
        xact(1'b1, fa(0), d3, rd, dfm, dbm);
        chk_i("R7 flat write no bulk", dbm, 0);
        chk_d("R7 flat lands after cache lines", fmem[4][DW-1:0], d3);
        xact(1'b0, fa(0), '0, rd, dfm, dbm);
        chk_d("R7 flat read back", rd, d3);
        ref_flat[0] = d3;
        xact(1'b1, fa(13), rand_line(), rd, dfm, dbm);
        xact(1'b0, fa(13), '0, rd, dfm, dbm);
        chk_d("R8 out-of-range flat read zero (R2 strap ignored)", rd, '0);
        random_phase(120);

        // hybrid half
        do_reset(3);
        xact(1'b0, 9'd1, '0, rd, dfm, dbm);
        xact(1'b0, 9'd5, '0, rd, dfm, dbm);
        xact(1'b0, 9'd1, '0, rd, dfm, dbm);
        chk_i("R3 half no aliasing", dbm, 0);
        random_phase(120);

        // flat
        do_reset(1);
        xact(1'b0, 9'd9, '0, rd, dfm, dbm);
        chk_i("R9 bypass no fast access", dfm, 0);
        chk_i("R9 bypass one bulk op", dbm, 1);
        chk_d("R9 bypass data", rd, bval(9));
        d1 = rand_line();
        xact(1'b1, 9'd9, d1, rd, dfm, dbm);
        chk_i("R9 write bypass no fast access", dfm, 0);
        chk_d("R9 write reaches bulk", bmem[9], d1);
        ref_bulk[9] = d1;
        d2 = rand_line();
        xact(1'b1, fa(15), d2, rd, dfm, dbm);
        xact(1'b0, fa(15), '0, rd, dfm, dbm);
        chk_d("R7 top flat line", rd, d2);
        ref_flat[15] = d2;
        random_phase(120);

        done = 1;
        report();
        $finish;
    end
endmodule